// File: doc/BRIEF.md
# Timer-Paced Parallel Pin Port

This block lets eight shared data pins serve one of two owners. In handshake mode the FIFO interface logic drives the pins as it always has. In port mode the pins act as a general-purpose parallel port. Each pin is an output or an input, set by a direction mask. Bytes that arrive on a valid/ready stream wait in a small queue. They are then applied to the pins one at a time, at a pace set by a programmable prescaler.

The prescaler produces one tick every `prescale + 1` clock cycles. The timer runs in both modes, so every mode change lands on a tick. On each tick in port mode with a byte waiting, the block does three things:

- It captures the pin levels as they stood just before the update and returns them on the sample stream.
- It drives the next queued byte.
- It raises a one-cycle sample strobe.

When the queue is empty, the pins keep their last value and no sample is produced. On the way back to handshake mode, all output enables are dropped for one cycle before the FIFO logic takes the pins again.

Top module: `bitbang_port`

## Requirements
- R1: After reset the block is in handshake mode. `fifoActive` is 1, `sampleValid` is 0, `inReady` is 1, and `pinOe` is 0 while `fifoOe` is 0.
- R2: In handshake mode, `pinOut` equals `fifoDout` and `pinOe` is all ones when `fifoOe` is 1 and all zeros otherwise. Queued bytes are not drained and no sample is produced.
- R3: In port mode with bytes queued, one byte is driven per tick. Consecutive `sampleValid` pulses are exactly `prescale + 1` cycles apart.
- R4: Queued bytes reach `pinOut` in the order they were accepted on the input stream.
- R5: In port mode, `pinOe` equals `dirMask`. A mask bit of 1 makes that pin an output, and a bit of 0 releases it.
- R6: On each update, `sampleData` holds the pin levels of the cycle before the update. Output bits carry the previously driven value and input bits carry the external level. `sampleValid` is high for exactly one cycle.
- R7: With the queue empty in port mode, `pinOut` holds its last value and `sampleValid` stays low.
- R8: Holding `DEPTH` bytes, the queue lowers `inReady`. A byte offered while `inReady` is 0 is dropped.
- R9: Mode changes happen only on a tick. Entering port mode takes at most `prescale + 1` cycles after `modeEn` rises. Returning to handshake mode takes at most `prescale + 2` cycles after it falls.
- R10: On leaving port mode there is exactly one cycle with `fifoActive` at 0 and `pinOe` at 0 before `fifoActive` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeEn | input | 1 | 1 requests port mode, 0 requests handshake mode |
| dirMask | input | WIDTH | Per-pin direction, 1 = output |
| prescale | input | PRESC_W | Tick interval minus one, in cycles |
| inData | input | WIDTH | Byte to queue |
| inValid | input | 1 | inData is offered |
| inReady | output | 1 | Queue can accept a byte |
| fifoDout | input | WIDTH | Pin values from the FIFO handshake logic |
| fifoOe | input | 1 | FIFO handshake logic wants to drive the pins |
| pinIn | input | WIDTH | Levels seen on the pins |
| pinOut | output | WIDTH | Pin drive values |
| pinOe | output | WIDTH | Per-pin output enables |
| sampleData | output | WIDTH | Captured pin levels |
| sampleValid | output | 1 | One-cycle strobe for sampleData |
| fifoActive | output | 1 | FIFO handshake logic owns the pins |

## Verification
Errors in the queue pointers show up at the next tick as a byte out of order, repeated or missing on `pinOut`. They also show up as a sample strobe on an empty queue. A timer miscount changes the spacing of `sampleValid` pulses by a cycle on the very next update. A bad mode sequencer shows as `fifoActive` toggling off a tick or too late, or as the pins driven in the same cycle that the FIFO logic takes over. Each case becomes visible within one tick period of the fault.

// File: rtl/bbport_pkg.sv
package bbport_pkg;

  typedef enum logic [1:0] {
    MODE_FIFO    = 2'd0,
    MODE_BITBANG = 2'd1,
    MODE_RELEASE = 2'd2
  } portMode_e;

  typedef struct packed {
    logic pop;        // take head byte from queue and drive it
    logic capture;    // latch pin levels into the sample register
    logic drivePins;  // port mode owns pins
    logic fifoOwns;   // handshake logic owns pins
  } ctrlStrobe_t;

endpackage

// File: rtl/bbport_ctrl.sv
module bbport_ctrl
  import bbport_pkg::*;
#(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeEn,
  input  logic [PRESC_W-1:0] prescale,
  input  logic               queueEmpty,
  output ctrlStrobe_t        stb
);

  logic [PRESC_W-1:0] tickCnt;
  logic               tick;
  portMode_e          mode, modeNext;

  assign tick = (tickCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN)     tickCnt <= '0;
    else if (tick) tickCnt <= prescale;
    else           tickCnt <= tickCnt - 1'b1;
  end

  always_comb begin
    modeNext = mode;
    unique case (mode)
      MODE_FIFO:    if (tick && modeEn)  modeNext = MODE_BITBANG;
      MODE_BITBANG: if (tick && !modeEn) modeNext = MODE_RELEASE;
      MODE_RELEASE: modeNext = MODE_FIFO;
      default:      modeNext = MODE_FIFO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) mode <= MODE_FIFO;
    else       mode <= modeNext;
  end

  always_comb begin
    stb.pop       = (mode == MODE_BITBANG) && tick && modeEn && !queueEmpty;
    stb.capture   = (mode == MODE_BITBANG) && tick && modeEn && !queueEmpty;
    stb.drivePins = (mode == MODE_BITBANG);
    stb.fifoOwns  = (mode == MODE_FIFO);
  end

  // R9: mode only moves on a tick (release step excepted)
  assert_mode_on_tick_R9: assert property (@(posedge clk) disable iff (!rstN)
    (mode != $past(mode)) |-> ($past(tick) || $past(mode) == MODE_RELEASE));

  // R10: release lasts exactly one cycle and leads to handshake mode
  assert_release_one_cycle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_RELEASE) |=> (mode == MODE_FIFO));

endmodule

// File: rtl/bbport_datapath.sv
module bbport_datapath
  import bbport_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      stb,
  input  logic [WIDTH-1:0] inData,
  input  logic             inValid,
  output logic             inReady,
  input  logic [WIDTH-1:0] dirMask,
  input  logic [WIDTH-1:0] fifoDout,
  input  logic             fifoOe,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  output logic [WIDTH-1:0] sampleData,
  output logic             sampleValid,
  output logic             queueEmpty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             push;
  logic [WIDTH-1:0] outReg;

  assign inReady    = (count != FULL_CNT);
  assign queueEmpty = (count == '0);
  assign push       = inValid && inReady;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push)    wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (stb.pop) rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({push, stb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outReg      <= '0;
      sampleData  <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= stb.capture;
      if (stb.capture) sampleData <= pinIn;
      if (stb.pop)     outReg     <= mem[rdPtr];
    end
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_pinMux
    assign pinOut[b] = stb.drivePins ? outReg[b]  : fifoDout[b];
    assign pinOe[b]  = stb.drivePins ? dirMask[b] : (stb.fifoOwns & fifoOe);
  end

  // R7: the sequencer never pops an empty queue
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.pop |-> !queueEmpty);

  // R6: a capture strobe yields exactly one sample pulse
  assert_sample_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> (sampleValid && $past(stb.capture)));

  // R8: occupancy never exceeds the queue depth
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

endmodule

// File: rtl/bitbang_port.sv
module bitbang_port
  import bbport_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int DEPTH   = 8,
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeEn,
  input  logic [WIDTH-1:0]   dirMask,
  input  logic [PRESC_W-1:0] prescale,
  input  logic [WIDTH-1:0]   inData,
  input  logic               inValid,
  output logic               inReady,
  input  logic [WIDTH-1:0]   fifoDout,
  input  logic               fifoOe,
  input  logic [WIDTH-1:0]   pinIn,
  output logic [WIDTH-1:0]   pinOut,
  output logic [WIDTH-1:0]   pinOe,
  output logic [WIDTH-1:0]   sampleData,
  output logic               sampleValid,
  output logic               fifoActive
);

  ctrlStrobe_t stb;
  logic        queueEmpty;

  bbport_ctrl #(.PRESC_W(PRESC_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeEn     (modeEn),
    .prescale   (prescale),
    .queueEmpty (queueEmpty),
    .stb        (stb)
  );

  bbport_datapath #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .inData      (inData),
    .inValid     (inValid),
    .inReady     (inReady),
    .dirMask     (dirMask),
    .fifoDout    (fifoDout),
    .fifoOe      (fifoOe),
    .pinIn       (pinIn),
    .pinOut      (pinOut),
    .pinOe       (pinOe),
    .sampleData  (sampleData),
    .sampleValid (sampleValid),
    .queueEmpty  (queueEmpty)
  );

  assign fifoActive = stb.fifoOwns;

  // R10: handshake logic takes over only after a cycle with all enables low
  assert_release_gap_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fifoActive) |-> ($past(pinOe) == '0));

  // R2: no samples while the handshake logic owns the pins
  assert_quiet_fifo_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fifoActive && $past(fifoActive)) |-> !sampleValid);

endmodule

// File: tb/sim_bitbang_port.sv
module sim_bitbang_port;

  localparam int DEPTH = 8;
  localparam int LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeEn = 1'b0;
  logic [7:0] dirMask = 8'h00;
  logic [7:0] prescale = 8'd0;
  logic [7:0] inData = 8'h00;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [7:0] fifoDout = 8'h00;
  logic       fifoOe = 1'b0;
  logic [7:0] pinIn;
  logic [7:0] pinOut, pinOe, sampleData;
  logic       sampleValid, fifoActive;
  logic [7:0] ext = 8'h00;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit monOn = 1'b0;
  bit done = 1'b0;
  logic [7:0] expQ [0:255];
  int wrIdx = 0;
  int rdIdx = 0;
  int lastCyc = -1;
  logic [7:0] lastOut = 8'h00;

  always #10 clk = ~clk;

  assign pinIn = (pinOut & pinOe) | (ext & ~pinOe);

  bitbang_port u0 (
    .clk(clk), .rstN(rstN), .modeEn(modeEn), .dirMask(dirMask),
    .prescale(prescale), .inData(inData), .inValid(inValid),
    .inReady(inReady), .fifoDout(fifoDout), .fifoOe(fifoOe),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .sampleData(sampleData), .sampleValid(sampleValid),
    .fifoActive(fifoActive)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Sample monitor, a quarter period after each rising edge
  always @(posedge clk) begin
    #5;
    cyc++;
    if (monOn && sampleValid) begin
      if (rdIdx >= wrIdx) begin
        check(1'b0, "R7 sample on empty queue", sampleData, 0);
      end else begin
        check(pinOut == expQ[rdIdx], "R4 byte order", pinOut, expQ[rdIdx]);
        check(sampleData == ((lastOut & dirMask) | (ext & ~dirMask)),
              "R6 sampled levels", sampleData, (lastOut & dirMask) | (ext & ~dirMask));
        check(pinOe == dirMask, "R5 output enables", pinOe, dirMask);
        if (lastCyc >= 0)
          check(cyc - lastCyc == int'(prescale) + 1, "R3 tick spacing",
                cyc - lastCyc, int'(prescale) + 1);
        lastOut = expQ[rdIdx];
        rdIdx++;
        lastCyc = cyc;
      end
    end
    if (monOn && fifoActive && sampleValid)
      check(1'b0, "R2 sample in handshake mode", 1, 0);
    if (cyc > LIMIT && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
      finishRun();
    end
  end

  task automatic waitPoll();
    @(posedge clk);
    #5;
  endtask

  task automatic offer(input logic [7:0] v, output bit took);
    @(negedge clk);
    inData  = v;
    inValid = 1'b1;
    took    = inReady;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    bit took;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    waitPoll();
    // R1 reset state
    check(fifoActive == 1'b1, "R1 fifoActive", fifoActive, 1);
    check(sampleValid == 1'b0, "R1 sampleValid", sampleValid, 0);
    check(inReady == 1'b1, "R1 inReady", inReady, 1);
    check(pinOe == 8'h00, "R1 pinOe", pinOe, 0);
    monOn = 1'b1;

    for (int run = 0; run < 16; run++) begin
      int p;
      logic [7:0] m;
      int c;
      bit seen;
      logic [7:0] prevOe;
      bit prevFifo;
      p = (run / 4 == 0) ? 0 : (run / 4 == 1) ? 1 : (run / 4 == 2) ? 2 : 5;
      case (run % 4)
        0: m = 8'hFF;
        1: m = 8'h0F;
        2: m = 8'hA5;
        default: m = 8'h00;
      endcase
      @(negedge clk);
      prescale = 8'(p);
      dirMask  = m;
      ext      = 8'(~(run * 29));
      fifoDout = 8'(run * 11 + 3);
      fifoOe   = 1'b0;
      lastCyc  = -1;

      // Fill the queue while in handshake mode
      for (int i = 0; i < DEPTH; i++) begin
        logic [7:0] b;
        b = 8'((run * 37 + i * 13 + 5));
        offer(b, took);
        check(took, "R8 accepted below depth", took, 1);
        if (took) begin expQ[wrIdx] = b; wrIdx++; end
      end
      check(inReady == 1'b0, "R8 full queue", inReady, 0);
      offer(8'h5A, took);
      check(!took, "R8 extra byte refused", took, 0);

      // R2: handshake mode leaves queue alone and passes FIFO values
      repeat (2 * p + 3) waitPoll();
      check(pinOut == fifoDout, "R2 pinOut", pinOut, fifoDout);
      check(pinOe == 8'h00, "R2 pinOe released", pinOe, 0);
      @(negedge clk); fifoOe = 1'b1;
      waitPoll();
      check(pinOe == 8'hFF, "R2 pinOe driven", pinOe, 8'hFF);
      check(rdIdx == wrIdx - DEPTH, "R2 queue untouched", rdIdx, wrIdx - DEPTH);

      // Enter port mode
      @(negedge clk); modeEn = 1'b1;
      c = 0; seen = 1'b0;
      for (int k = 1; k <= p + 3; k++) begin
        waitPoll();
        if (!fifoActive && !seen) begin seen = 1'b1; c = k; end
      end
      check(seen && c <= p + 1, "R9 entry latency", c, p + 1);

      // Wait for the queue to drain
      for (int k = 0; k < (DEPTH + 2) * (p + 1) + 4 && rdIdx < wrIdx; k++) waitPoll();
      check(rdIdx == wrIdx, "R3 all bytes driven", rdIdx, wrIdx);

      // R7: empty queue holds value, no samples (monitor flags strays)
      repeat (3 * (p + 1)) waitPoll();
      check(pinOut == lastOut, "R7 held value", pinOut, lastOut);
      check(sampleValid == 1'b0, "R7 no sample", sampleValid, 0);

      // Leave port mode
      prevOe = pinOe; prevFifo = fifoActive;
      @(negedge clk); modeEn = 1'b0;
      c = 0; seen = 1'b0;
      for (int k = 1; k <= p + 4 && !seen; k++) begin
        waitPoll();
        if (fifoActive) begin
          seen = 1'b1; c = k;
          check(prevOe == 8'h00 && !prevFifo, "R10 release gap", prevOe, 0);
        end else begin
          prevOe = pinOe; prevFifo = fifoActive;
        end
      end
      check(seen && c <= p + 2, "R9 exit latency", c, p + 2);
      check(pinOut == fifoDout && pinOe == 8'hFF, "R2 handshake restored",
            pinOe, 8'hFF);
    end
    finishRun();
  end

endmodule